// File: doc/BRIEF.md
# Jump Target Cache with Page Invalidation

This block keeps destinations of recently resolved jumps and branches so that instruction fetch can redirect without waiting for the jump to resolve. Fetch presents its current address each cycle. When a valid entry exists for that address, the block returns the stored destination, and fetch can steer to it straight away instead of losing three cycles of discarded instructions. When a jump or branch resolves, its source and destination are handed to the update port. The update reaches the storage a fixed number of cycles later, which matches the write-back point of the pipeline.

Stored entries must never outlive the code they describe. A write to any memory page removes every entry whose originating instruction sits in that page. A context flush removes all entries, and it also cancels updates that are still in flight. Jumps whose target is only known at run time are checked on a separate port: the speculated destination is compared with the real one, a disagreement is flagged for recovery, and the slot that produced the guess is dropped.

The storage is direct-mapped with 16 slots. Page numbers are held in flops so that a whole page can be cleared in one cycle. Tag remainders and destinations sit in an array with synchronous read, a layout that an FPGA can map onto block RAM.

Top module: `jump_target_cache`

## Requirements
- R1: While reset is high and in the cycle after it, lk_hit and spec_wrong are 0 and lk_target is 0. Reset leaves no slot valid.
- R2: An address is split into slot index = bits [4:1], tag remainder = bits [7:5] and page = bits [15:8]. lk_hit and lk_target show the result for the lk_addr sampled at the previous rising edge. On a hit, lk_target is the stored destination.
- R3: If the slot is valid but its page or tag remainder differs from the lookup address, the result is a miss. On a miss lk_target reads 0.
- R4: An update sampled at edge e can first be seen by a lookup sampled at edge e+4. A lookup sampled at edge e+3 does not see it.
- R5: A later update that maps to the same slot replaces the earlier source and destination.
- R6: pgw_en with pgw_num sampled at edge e invalidates every slot whose page equals pgw_num. Lookups sampled from edge e+1 onward miss those slots. The lookup sampled at edge e still sees them. Slots in other pages are unaffected.
- R7: ctx_flush sampled at an edge invalidates every slot.
- R8: An update is discarded if, at any of edges e to e+3, ctx_flush is high or pgw_en is high with pgw_num equal to the update's source page. This includes the edge at which the update would be written.
- R9: spec_wrong is 1 in the cycle after an edge at which spec_en was high and spec_guess differed from spec_real. Otherwise it is 0.
- R10: A disagreement under R9 invalidates the slot indexed by spec_src bits [4:1], and this takes priority over an update to the same slot at the same edge. An agreeing check leaves the slot valid.
- R11: Address bit 0 takes no part in lookup, so addresses that differ only in bit 0 give the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lk_addr | input | 16 | Fetch address to look up |
| lk_hit | output | 1 | Lookup found a valid matching slot |
| lk_target | output | 16 | Stored destination on a hit, 0 on a miss |
| upd_en | input | 1 | Resolved jump or branch update |
| upd_src | input | 16 | Address of the resolved instruction |
| upd_dst | input | 16 | Its resolved destination |
| pgw_en | input | 1 | A memory page has been written |
| pgw_num | input | 8 | Number of the written page (address bits [15:8]) |
| ctx_flush | input | 1 | Context switch: invalidate everything |
| spec_en | input | 1 | Compare a speculated dynamic target |
| spec_src | input | 16 | Address of the dynamic jump |
| spec_guess | input | 16 | Destination that was speculated |
| spec_real | input | 16 | Destination actually computed |
| spec_wrong | output | 1 | Registered disagreement flag |

## Verification
Lookup results and the spec_wrong flag are due in the cycle after the edge that sampled their inputs. The bench therefore drives on the falling edge and compares on the next falling edge against a model advanced at the rising edge in between. Updates are due four edges after sampling, and invalidations take effect one edge after sampling. The directed cases probe the last cycle before each becomes visible and the first cycle after, with literal expected values. The random phase reaches the same timing points by running the bench model edge by edge.

// File: rtl/jtc_pkg.sv
package jtc_pkg;
  localparam int ADDR_W     = 16;
  localparam int PAGE_OFF_W = 8;
  localparam int IDX_W      = 4;
  localparam int ALIGN_W    = 1;
  localparam int ENTRIES    = 1 << IDX_W;
  localparam int PAGE_W     = ADDR_W - PAGE_OFF_W;
  localparam int TLO_W      = PAGE_OFF_W - IDX_W - ALIGN_W;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [PAGE_W-1:0] page_t;
  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [TLO_W-1:0]  tlo_t;

  typedef struct packed {
    logic  vld;
    addr_t src;
    addr_t dst;
  } upd_t;

  function automatic page_t page_of(addr_t a);
    return a[ADDR_W-1:PAGE_OFF_W];
  endfunction

  function automatic idx_t idx_of(addr_t a);
    return a[IDX_W+ALIGN_W-1:ALIGN_W];
  endfunction

  function automatic tlo_t tlo_of(addr_t a);
    return a[PAGE_OFF_W-1:IDX_W+ALIGN_W];
  endfunction

  // true when an update from src must be dropped at this edge
  function automatic logic cancel(addr_t src, logic flush, logic pg_en, page_t pg);
    return flush || (pg_en && (page_of(src) == pg));
  endfunction
endpackage

// File: rtl/jtc_upd_pipe.sv
module jtc_upd_pipe
  import jtc_pkg::*;
#(
  parameter int STAGES = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  upd_t                up_in,
  input  logic                flush,
  input  logic                pg_en,
  input  logic [PAGE_W-1:0]   pg_num,
  output upd_t                up_out
);
  upd_t st [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_st
    upd_t prev;
    if (s == 0) begin : g_head
      assign prev = up_in;
    end else begin : g_body
      assign prev = st[s-1];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        st[s] <= '0;
      end else begin
        st[s]     <= prev;
        st[s].vld <= prev.vld && !cancel(prev.src, flush, pg_en, pg_num);
      end
    end

    // R8: nothing survives a flush inside the delay line
    assert_pipe_flush_R8: assert property (@(posedge clk) disable iff (rst)
      flush |=> !st[s].vld)
      else $error("pipe stage kept an update across a flush");
  end

  assign up_out = st[STAGES-1];
endmodule

// File: rtl/jtc_store.sv
module jtc_store
  import jtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] lk_addr,
  input  upd_t              wr,
  input  logic              flush,
  input  logic              pg_en,
  input  logic [PAGE_W-1:0] pg_num,
  input  logic              inv_en,
  input  logic [IDX_W-1:0]  inv_idx,
  output logic              lk_hit,
  output logic [ADDR_W-1:0] lk_dst
);
  localparam int RW = TLO_W + ADDR_W;

  logic [RW-1:0]      mem [ENTRIES];
  logic [RW-1:0]      rd_q;
  logic [ENTRIES-1:0] vld;
  page_t              pg_q [ENTRIES];
  logic               rd_v_q;
  page_t              rd_pg_q, lk_pg_q;
  tlo_t               lk_tlo_q;
  logic               we;
  idx_t               widx, ridx;

  assign widx = idx_of(wr.src);
  assign ridx = idx_of(lk_addr);
  assign we   = wr.vld && !cancel(wr.src, flush, pg_en, pg_num);

  // array part: one write port, read-first synchronous read
  always_ff @(posedge clk) begin
    if (we) mem[widx] <= {tlo_of(wr.src), wr.dst};
    rd_q <= mem[ridx];
  end

  // valid bits and page numbers live in flops for one-cycle bulk clears
  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      for (int i = 0; i < ENTRIES; i++) pg_q[i] <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        logic wr_i;
        wr_i = we && (widx == idx_t'(i));
        if (flush || (inv_en && inv_idx == idx_t'(i)) ||
            (pg_en && pg_q[i] == pg_num && !wr_i))
          vld[i] <= 1'b0;
        else if (wr_i)
          vld[i] <= 1'b1;
        if (wr_i) pg_q[i] <= page_of(wr.src);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_v_q   <= 1'b0;
      rd_pg_q  <= '0;
      lk_pg_q  <= '0;
      lk_tlo_q <= '0;
    end else begin
      rd_v_q   <= vld[ridx];
      rd_pg_q  <= pg_q[ridx];
      lk_pg_q  <= page_of(lk_addr);
      lk_tlo_q <= tlo_of(lk_addr);
    end
  end

  assign lk_hit = rd_v_q && (rd_pg_q == lk_pg_q) && (rd_q[RW-1:ADDR_W] == lk_tlo_q);
  assign lk_dst = lk_hit ? rd_q[ADDR_W-1:0] : '0;

  // R7: a flush leaves no valid slot behind
  assert_flush_clears_R7: assert property (@(posedge clk) disable iff (rst)
    flush |=> (vld == '0))
    else $error("slot valid after flush");

  for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
    // R6: a slot in the written page is gone unless it was just refilled elsewhere
    assert_page_inv_R6: assert property (@(posedge clk) disable iff (rst)
      (pg_en && pg_q[g] == pg_num) |=> (!vld[g] || pg_q[g] != $past(pg_num)))
      else $error("slot survived a write to its page");
    // R10: mismatch invalidation beats a same-edge refill
    assert_inv_wins_R10: assert property (@(posedge clk) disable iff (rst)
      (inv_en && inv_idx == idx_t'(g) && wr.vld && widx == idx_t'(g)) |=> !vld[g])
      else $error("refill overrode mismatch invalidation");
  end
endmodule

// File: rtl/jump_target_cache.sv
module jump_target_cache
  import jtc_pkg::*;
#(
  parameter int WR_LAT = 4  // edges from update sample to first visible lookup, >= 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [ADDR_W-1:0] lk_target,
  input  logic              upd_en,
  input  logic [ADDR_W-1:0] upd_src,
  input  logic [ADDR_W-1:0] upd_dst,
  input  logic              pgw_en,
  input  logic [PAGE_W-1:0] pgw_num,
  input  logic              ctx_flush,
  input  logic              spec_en,
  input  logic [ADDR_W-1:0] spec_src,
  input  logic [ADDR_W-1:0] spec_guess,
  input  logic [ADDR_W-1:0] spec_real,
  output logic              spec_wrong
);
  localparam int STAGES = WR_LAT - 1;

  upd_t up_in, up_out;
  logic inv_en;

  assign up_in  = '{vld: upd_en, src: upd_src, dst: upd_dst};
  assign inv_en = spec_en && (spec_guess != spec_real);

  jtc_upd_pipe #(.STAGES(STAGES)) i_pipe (
    .clk    (clk),
    .rst    (rst),
    .up_in  (up_in),
    .flush  (ctx_flush),
    .pg_en  (pgw_en),
    .pg_num (pgw_num),
    .up_out (up_out)
  );

  jtc_store i_store (
    .clk     (clk),
    .rst     (rst),
    .lk_addr (lk_addr),
    .wr      (up_out),
    .flush   (ctx_flush),
    .pg_en   (pgw_en),
    .pg_num  (pgw_num),
    .inv_en  (inv_en),
    .inv_idx (idx_of(spec_src)),
    .lk_hit  (lk_hit),
    .lk_dst  (lk_target)
  );

  always_ff @(posedge clk) begin
    if (rst) spec_wrong <= 1'b0;
    else     spec_wrong <= inv_en;
  end

  // R1: outputs quiet right after a reset edge
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!lk_hit && !spec_wrong && lk_target == '0))
    else $error("outputs active after reset");

  // R9: the flag only follows a disagreeing check
  assert_flag_cause_R9: assert property (@(posedge clk) disable iff (rst)
    spec_wrong |-> ($past(spec_en) && $past(spec_guess) != $past(spec_real)))
    else $error("spec_wrong without a disagreeing check");
endmodule

// File: tb/test_jump_target_cache.sv
`timescale 1ns/1ps
module test_jump_target_cache;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] lk_addr = '0, upd_src = '0, upd_dst = '0;
  logic [15:0] spec_src = '0, spec_guess = '0, spec_real = '0;
  logic [7:0]  pgw_num = '0;
  logic        upd_en = 0, pgw_en = 0, ctx_flush = 0, spec_en = 0;
  logic        lk_hit, spec_wrong;
  logic [15:0] lk_target;

  always #2.5 clk = ~clk;

  jump_target_cache i_jump_target_cache (
    .clk(clk), .rst(rst), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_target(lk_target),
    .upd_en(upd_en), .upd_src(upd_src), .upd_dst(upd_dst),
    .pgw_en(pgw_en), .pgw_num(pgw_num), .ctx_flush(ctx_flush),
    .spec_en(spec_en), .spec_src(spec_src), .spec_guess(spec_guess),
    .spec_real(spec_real), .spec_wrong(spec_wrong));

  int    nchk = 0, nerr = 0;
  bit    done = 0;
  string cur_req = "R1";

  // bench model of the requirements
  logic        mv [16];
  logic [7:0]  mpg [16];
  logic [2:0]  mtl [16];
  logic [15:0] mtg [16];
  logic        pv [3];
  logic [15:0] ps [3], pd [3];
  logic        e_hit, e_wrong;
  logic [15:0] e_tgt;

  function automatic bit killed(logic [15:0] s);
    return ctx_flush || (pgw_en && s[15:8] == pgw_num);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 16; i++) mv[i] = 0;
    for (int i = 0; i < 3; i++) pv[i] = 0;
    e_hit = 0; e_tgt = '0; e_wrong = 0;
  endtask

  task automatic model_edge();
    int ix, j;
    ix = int'(lk_addr[4:1]);
    e_hit   = mv[ix] && mpg[ix] == lk_addr[15:8] && mtl[ix] == lk_addr[7:5];
    e_tgt   = e_hit ? mtg[ix] : 16'h0;
    e_wrong = spec_en && (spec_guess != spec_real);
    if (pv[2] && !killed(ps[2])) begin
      j = int'(ps[2][4:1]);
      mv[j] = 1; mpg[j] = ps[2][15:8]; mtl[j] = ps[2][7:5]; mtg[j] = pd[2];
    end
    for (int i = 0; i < 16; i++)
      if (ctx_flush || (pgw_en && mpg[i] == pgw_num)) mv[i] = 0;
    if (e_wrong) mv[int'(spec_src[4:1])] = 0;
    pv[2] = pv[1] && !killed(ps[1]); ps[2] = ps[1]; pd[2] = pd[1];
    pv[1] = pv[0] && !killed(ps[0]); ps[1] = ps[0]; pd[1] = pd[0];
    pv[0] = upd_en && !killed(upd_src); ps[0] = upd_src; pd[0] = upd_dst;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    if (rst) model_reset(); else model_edge();
    @(negedge clk);
    chk({cur_req, " hit"}, 32'(lk_hit), 32'(e_hit));
    chk({cur_req, " target"}, 32'(lk_target), 32'(e_tgt));
    chk("R9 flag", 32'(spec_wrong), 32'(e_wrong));
  endtask

  task automatic clr();
    upd_en = 0; pgw_en = 0; ctx_flush = 0; spec_en = 0;
  endtask

  task automatic upd(input logic [15:0] s, input logic [15:0] d);
    upd_en = 1; upd_src = s; upd_dst = d;
  endtask

  function automatic logic [15:0] rnd_addr();
    logic [7:0] pg;
    pg = ($urandom % 2 == 0) ? 8'h12 : 8'h56;
    return {pg, 2'b00, 1'($urandom), 4'($urandom), 1'($urandom)};
  endfunction

  localparam logic [15:0] A = 16'h1234;  // page 12, slot 10, tag remainder 1
  localparam logic [15:0] B = 16'h5602;  // page 56, slot 1, tag remainder 0

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    repeat (3) step();
    rst = 0;

    cur_req = "R1"; lk_addr = A; step();
    chk("R1 hit", 32'(lk_hit), 0); chk("R1 target", 32'(lk_target), 0);

    cur_req = "R4"; upd(A, 16'hBEEF); step(); clr();
    repeat (3) step();
    chk("R4 not yet visible", 32'(lk_hit), 0);
    step();
    chk("R4 visible", 32'(lk_hit), 1); chk("R2 target", 32'(lk_target), 32'h0000BEEF);

    cur_req = "R11"; lk_addr = A | 16'h1; step();
    chk("R11 bit0 ignored", 32'(lk_hit), 1);

    cur_req = "R3"; lk_addr = A ^ 16'h0020; step();
    chk("R3 tag differs", 32'(lk_hit), 0); chk("R3 target zero", 32'(lk_target), 0);
    lk_addr = A ^ 16'h0100; step();
    chk("R3 page differs", 32'(lk_hit), 0);

    cur_req = "R5"; upd(A, 16'h1111); step(); upd(B, 16'hCAFE); step(); clr();
    lk_addr = A; repeat (3) step();
    chk("R5 replaced", 32'(lk_target), 32'h00001111);
    lk_addr = B; step();
    chk("R5 second slot", 32'(lk_target), 32'h0000CAFE);

    cur_req = "R6"; lk_addr = A; pgw_en = 1; pgw_num = 8'h12; step(); clr();
    chk("R6 same edge still hits", 32'(lk_hit), 1);
    step();
    chk("R6 invalidated", 32'(lk_hit), 0);
    lk_addr = B; step();
    chk("R6 other page kept", 32'(lk_hit), 1);

    cur_req = "R10"; lk_addr = A; upd(A, 16'h2222); step(); clr();
    repeat (4) step();
    chk("R10 setup", 32'(lk_target), 32'h00002222);
    spec_en = 1; spec_src = A; spec_guess = 16'h2222; spec_real = 16'h2222; step(); clr();
    chk("R9 agree", 32'(spec_wrong), 0);
    step();
    chk("R10 agree keeps slot", 32'(lk_hit), 1);
    spec_en = 1; spec_real = 16'h3333; step(); clr();
    chk("R9 disagree", 32'(spec_wrong), 1);
    step();
    chk("R10 slot dropped", 32'(lk_hit), 0);
    chk("R9 flag one cycle", 32'(spec_wrong), 0);
    lk_addr = B; step();
    chk("R10 other slot kept", 32'(lk_hit), 1);

    cur_req = "R8"; lk_addr = A; upd(A, 16'h4444); step(); clr(); step();
    pgw_en = 1; pgw_num = 8'h12; step(); clr(); step(); step();
    chk("R8 page write in flight", 32'(lk_hit), 0);
    upd(A, 16'h5555); step(); clr(); step(); step();
    pgw_en = 1; pgw_num = 8'h77; step(); clr(); step();
    chk("R8 other page write harmless", 32'(lk_target), 32'h00005555);
    upd(A, 16'h6666); step(); clr(); step(); step();
    ctx_flush = 1; step(); clr(); step();
    chk("R8 flush at write edge", 32'(lk_hit), 0);

    cur_req = "R7"; lk_addr = B; step();
    chk("R7 flush cleared all", 32'(lk_hit), 0);

    cur_req = "R2";
    for (int n = 0; n < 4000; n++) begin
      lk_addr = rnd_addr();
      upd_en = ($urandom % 4 == 0); upd_src = rnd_addr(); upd_dst = 16'($urandom);
      pgw_en = ($urandom % 40 == 0); pgw_num = ($urandom % 2 == 0) ? 8'h12 : 8'h56;
      ctx_flush = ($urandom % 300 == 0);
      spec_en = ($urandom % 8 == 0); spec_src = rnd_addr();
      spec_guess = 16'($urandom);
      spec_real = ($urandom % 2 == 0) ? spec_guess : 16'($urandom);
      step();
    end
    clr();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end
endmodule